// File: doc/BRIEF.md
# Clock-Enable Power-Down Sequencer

This block sits on the controller side of a DDR2 memory path and owns the clock-enable pin (CKE). It watches each command the controller issues, along with the completion strobes of data bursts and the open-row status of every bank. From these it decides when the memory may be put into power-down and when it must come back out.

Entry happens only after a programmable run of consecutive idle cycles. A cycle is idle when no burst is in flight, no read postamble or write-recovery window is open, no mode-register window is open, and no wake or refresh request is present. At entry the block drops CKE and latches whether any bank held an open row. An open row means active power-down; all banks closed means precharge power-down.

The block brings CKE back high on a wake request, on a refresh-due indication, or when the refresh-limited maximum residency runs out. It never does so before the minimum low time has passed. After exit, a blocked flag holds off new commands for a programmable number of cycles, and that count is chosen by the power-down type.

The command port only observes the controller and cannot push back. Flow control runs the other way: while `cmd_blocked` is high, the controller must issue NOP or DESELECT and nothing else. All other pins are plain level signals sampled on the rising clock edge.

Top module: `cke_pd_sequencer`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first entry, `cke` is 1, `cmd_blocked` is 0 and `pd_is_active` is 0.
- R2: Command codes are 0 NOP/DESELECT, 1 READ, 2 WRITE, 3 mode register set, 4 extended mode register set, 5 ACTIVATE, 6 PRECHARGE and 7 REFRESH. A cycle is idle when none of the busy conditions of R3 to R5 holds, no command with a non-zero code is valid, and both `wake_req` and `refresh_due` are 0. With `cfg_idle_cycles` = N (0 acts as 1), `cke` falls at the clock edge that ends the Nth consecutive idle cycle.
- R3: A READ (code 1) keeps the block busy from its issue cycle until its `burst_done` (with `burst_is_wr` = 0). It then stays busy for RD_POST more cycles. If the `burst_done` edge is t, the first idle cycle follows edge t+RD_POST.
- R4: A WRITE (code 2) keeps the block busy until its `burst_done` (with `burst_is_wr` = 1). It then stays busy for WR_POST + max(T_WR, WTR) cycles, where WTR = max(2, ceil(T_WTR_PS / T_CK_PS)).
- R5: A mode-register command (code 3 or 4) keeps the block busy for T_MRD cycles after its issue edge.
- R6: `pd_is_active` is set to 1 at entry if any bit of `bank_open` was 1 in the entry cycle, and to 0 otherwise. While `cke` is low it does not change, whatever `bank_open` does.
- R7: After entry, `cke` stays low for at least CKE_MIN cycles. A one-cycle `wake_req` pulse that arrives earlier is held, and exit then happens at exactly CKE_MIN cycles.
- R8: A high `refresh_due` during power-down forces exit at once if CKE_MIN cycles have already passed, and at CKE_MIN otherwise.
- R9: With no wake or refresh request, `cke` returns high after exactly MAX_RES low cycles.
- R10: `cmd_blocked` is 1 while `cke` is low. After `cke` rises, it stays 1 for `cfg_xp_act` cycles after active power-down, or `cfg_xp_pre` cycles after precharge power-down.
- R11: While the block is not in power-down, a held `wake_req` or `refresh_due` prevents entry. Entry then follows N idle cycles after the request is released.
- R12: `cke` falls only at the end of a cycle in which no command with a non-zero code was valid, and never while a burst, recovery window or mode-register window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 3 | Command code as listed in R2 |
| burst_done | input | 1 | Last data beat of the oldest outstanding burst |
| burst_is_wr | input | 1 | The completing burst is a write |
| bank_open | input | NBANKS | One bit per bank, 1 when a row is open |
| refresh_due | input | 1 | Level request: refresh must be issued soon |
| wake_req | input | 1 | Request to leave power-down |
| cfg_idle_cycles | input | CW | Idle cycles required before entry |
| cfg_xp_act | input | CW | Blocked cycles after leaving active power-down |
| cfg_xp_pre | input | CW | Blocked cycles after leaving precharge power-down |
| cke | output | 1 | Clock enable to the memory |
| cmd_blocked | output | 1 | Controller must issue only NOP/DESELECT |
| pd_is_active | output | 1 | 1 for active, 0 for precharge power-down (latched at entry) |

## Verification
The assertions take the controller at its word. It pulses `burst_done` once per READ or WRITE, in issue order. It issues only code 0 while `cmd_blocked` is high. It holds `refresh_due` until power-down has been left. The bench keeps to these rules: every burst it starts receives exactly one completion, commands are driven only in cycles where the block is not in power-down, and refresh is held as a level until `cke` is seen high again. Within those rules it sweeps the idle threshold, both burst kinds, mode-register commands, all sixteen bank-open patterns and both exit-delay settings.

// File: rtl/cke_pd_pkg.sv
package cke_pd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_RD   = 3'd1,
    CMD_WR   = 3'd2,
    CMD_MRS  = 3'd3,
    CMD_EMRS = 3'd4,
    CMD_ACT  = 3'd5,
    CMD_PRE  = 3'd6,
    CMD_REF  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    PS_ON   = 2'd0,
    PS_DOWN = 2'd1,
    PS_WAKE = 2'd2
  } pd_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cdiv(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

endpackage

// File: rtl/pd_window_cnt.sv
module pd_window_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         active
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] dec;

  // count down by one each cycle, stopping at zero
  assign dec = (cnt_q != '0) ? cnt_q - W'(1) : '0;

  // a new load never shortens a window that is already running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (load && (len > dec)) cnt_q <= len;
    else                          cnt_q <= dec;
  end

  assign active = (cnt_q != '0);

endmodule

// File: rtl/pd_busy_track.sv
module pd_busy_track
  import cke_pd_pkg::*;
#(
  parameter int MAX_OUT  = 4,
  parameter int RD_HOLD  = 2,
  parameter int WR_HOLD  = 4,
  parameter int MRD_HOLD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_type,
  input  logic       burst_done,
  input  logic       burst_is_wr,
  output logic       cmd_live,
  output logic       busy
);

  localparam int OW = $clog2(MAX_OUT + 1);
  localparam int HW = $clog2(imax(imax(RD_HOLD, WR_HOLD), 1) + 1);
  localparam int MW = $clog2(imax(MRD_HOLD, 1) + 1);

  cmd_e            cmd;
  logic            inc;
  logic            dec;
  logic [OW-1:0]   out_q;
  logic            rec_active;
  logic            mrd_active;
  logic            mrd_load;
  logic [HW-1:0]   rec_len;

  assign cmd      = cmd_e'(cmd_type);
  assign cmd_live = cmd_valid && (cmd != CMD_NOP);
  assign inc      = cmd_valid && ((cmd == CMD_RD) || (cmd == CMD_WR));
  assign dec      = burst_done && (out_q != '0);
  assign mrd_load = cmd_valid && ((cmd == CMD_MRS) || (cmd == CMD_EMRS));
  assign rec_len  = burst_is_wr ? HW'(WR_HOLD) : HW'(RD_HOLD);

  // bursts issued but not yet finished transferring data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (out_q != OW'(MAX_OUT)) out_q <= out_q + OW'(1);
        2'b01:   out_q <= out_q - OW'(1);
        default: out_q <= out_q;
      endcase
    end
  end

  // postamble / write-recovery window after the last data beat
  pd_window_cnt #(.W(HW)) u_rec (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (burst_done),
    .len    (rec_len),
    .active (rec_active)
  );

  // mode-register command time
  pd_window_cnt #(.W(MW)) u_mrd (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (mrd_load),
    .len    (MW'(MRD_HOLD)),
    .active (mrd_active)
  );

  assign busy = (out_q != '0) || rec_active || mrd_active;

endmodule

// File: rtl/pd_idle_timer.sv
module pd_idle_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          idle,
  input  logic [CW-1:0] cfg_idle_cycles,
  output logic          go
);

  logic [CW-1:0] idle_cnt;
  logic [CW:0]   seen;

  // consecutive idle cycles before the current one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    idle_cnt <= '0;
    else if (!enable || !idle)     idle_cnt <= '0;
    else if (idle_cnt != '1)       idle_cnt <= idle_cnt + CW'(1);
  end

  // counting the current cycle too; a threshold of 0 behaves as 1
  assign seen = {1'b0, idle_cnt} + (CW+1)'(1);
  assign go   = enable && idle && (seen >= {1'b0, cfg_idle_cycles});

endmodule

// File: rtl/pd_state_fsm.sv
module pd_state_fsm
  import cke_pd_pkg::*;
#(
  parameter int NBANKS  = 4,
  parameter int CW      = 8,
  parameter int CKE_MIN = 3,
  parameter int MAX_RES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [NBANKS-1:0] bank_open,
  input  logic              wake_req,
  input  logic              refresh_due,
  input  logic [CW-1:0]     cfg_xp_act,
  input  logic [CW-1:0]     cfg_xp_pre,
  output logic              in_on,
  output logic              cke,
  output logic              cmd_blocked,
  output logic              pd_is_active
);

  localparam int RW = $clog2(MAX_RES + 2);

  pd_state_e     state_q;
  logic [RW-1:0] res_q;
  logic [CW-1:0] xp_q;
  logic          wake_pend;
  logic          cke_q;
  logic          act_q;
  logic          min_met;
  logic          leave;
  logic [CW-1:0] xp_sel;

  assign min_met = (res_q >= RW'(CKE_MIN));
  assign leave   = min_met &&
                   (wake_pend || wake_req || refresh_due || (res_q >= RW'(MAX_RES)));
  assign xp_sel  = act_q ? cfg_xp_act : cfg_xp_pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PS_ON;
      res_q     <= '0;
      xp_q      <= '0;
      wake_pend <= 1'b0;
      cke_q     <= 1'b1;
      act_q     <= 1'b0;
    end else begin
      case (state_q)
        PS_ON: begin
          if (go) begin
            state_q   <= PS_DOWN;
            cke_q     <= 1'b0;
            act_q     <= |bank_open;
            res_q     <= RW'(1);
            wake_pend <= 1'b0;
          end
        end
        PS_DOWN: begin
          // a wake that arrives too early is kept until the minimum expires
          wake_pend <= wake_pend | wake_req;
          if (res_q != RW'(MAX_RES)) res_q <= res_q + RW'(1);
          if (leave) begin
            cke_q     <= 1'b1;
            wake_pend <= 1'b0;
            xp_q      <= xp_sel;
            state_q   <= (xp_sel == '0) ? PS_ON : PS_WAKE;
          end
        end
        PS_WAKE: begin
          xp_q <= xp_q - CW'(1);
          if (xp_q == CW'(1)) state_q <= PS_ON;
        end
        default: state_q <= PS_ON;
      endcase
    end
  end

  assign in_on        = (state_q == PS_ON);
  assign cke          = cke_q;
  assign cmd_blocked  = (state_q != PS_ON);
  assign pd_is_active = act_q;

endmodule

// File: rtl/cke_pd_sequencer.sv
module cke_pd_sequencer
  import cke_pd_pkg::*;
#(
  parameter int NBANKS    = 4,
  parameter int CW        = 8,
  parameter int MAX_OUT   = 4,
  parameter int RD_POST   = 2,
  parameter int WR_POST   = 1,
  parameter int T_WR      = 2,
  parameter int T_WTR_PS  = 7500,
  parameter int T_CK_PS   = 3000,
  parameter int T_MRD     = 2,
  parameter int CKE_MIN   = 3,
  parameter int MAX_RES   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_type,
  input  logic              burst_done,
  input  logic              burst_is_wr,
  input  logic [NBANKS-1:0] bank_open,
  input  logic              refresh_due,
  input  logic              wake_req,
  input  logic [CW-1:0]     cfg_idle_cycles,
  input  logic [CW-1:0]     cfg_xp_act,
  input  logic [CW-1:0]     cfg_xp_pre,
  output logic              cke,
  output logic              cmd_blocked,
  output logic              pd_is_active
);

  localparam int WTR_CK  = imax(2, cdiv(T_WTR_PS, T_CK_PS));
  localparam int WR_HOLD = WR_POST + imax(T_WR, WTR_CK);

  logic cmd_live;
  logic busy;
  logic idle;
  logic in_on;
  logic go;

  pd_busy_track #(
    .MAX_OUT  (MAX_OUT),
    .RD_HOLD  (RD_POST),
    .WR_HOLD  (WR_HOLD),
    .MRD_HOLD (T_MRD)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_type    (cmd_type),
    .burst_done  (burst_done),
    .burst_is_wr (burst_is_wr),
    .cmd_live    (cmd_live),
    .busy        (busy)
  );

  assign idle = !busy && !cmd_live && !wake_req && !refresh_due;

  pd_idle_timer #(.CW(CW)) u_idle (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable          (in_on),
    .idle            (idle),
    .cfg_idle_cycles (cfg_idle_cycles),
    .go              (go)
  );

  pd_state_fsm #(
    .NBANKS  (NBANKS),
    .CW      (CW),
    .CKE_MIN (CKE_MIN),
    .MAX_RES (MAX_RES)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (go),
    .bank_open    (bank_open),
    .wake_req     (wake_req),
    .refresh_due  (refresh_due),
    .cfg_xp_act   (cfg_xp_act),
    .cfg_xp_pre   (cfg_xp_pre),
    .in_on        (in_on),
    .cke          (cke),
    .cmd_blocked  (cmd_blocked),
    .pd_is_active (pd_is_active)
  );

endmodule

// File: rtl/cke_pd_sequencer_chk.sv
module cke_pd_sequencer_chk #(
  parameter int CKE_MIN = 3,
  parameter int MAX_RES = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_type,
  input logic       busy,
  input logic       cke,
  input logic       cmd_blocked,
  input logic       pd_is_active
);

  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   low_cnt <= '0;
    else if (cke)                 low_cnt <= '0;
    else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 16'd1;
  end

  assert_fall_on_nop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(!cmd_valid || (cmd_type == 3'd0)));

  assert_no_fall_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> !$past(busy));

  assert_low_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cmd_blocked);

  assert_type_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> $stable(pd_is_active));

  assert_min_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (low_cnt >= 16'(CKE_MIN)));

  assert_max_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= 16'(MAX_RES));

endmodule

bind cke_pd_sequencer cke_pd_sequencer_chk #(
  .CKE_MIN (CKE_MIN),
  .MAX_RES (MAX_RES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_type     (cmd_type),
  .busy         (busy),
  .cke          (cke),
  .cmd_blocked  (cmd_blocked),
  .pd_is_active (pd_is_active)
);

// File: tb/test_cke_pd_sequencer.sv
module test_cke_pd_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NBANKS   = 4;
  localparam int CW       = 8;
  localparam int RD_POST  = 2;
  localparam int WR_POST  = 1;
  localparam int T_WR     = 2;
  localparam int T_WTR_PS = 7500;
  localparam int T_CK_PS  = 3000;
  localparam int T_MRD    = 2;
  localparam int CKE_MIN  = 3;
  localparam int MAX_RES  = 40;

  localparam int WTR_EXP = ((T_WTR_PS + T_CK_PS - 1) / T_CK_PS > 2) ?
                           (T_WTR_PS + T_CK_PS - 1) / T_CK_PS : 2;
  localparam int WR_EXP  = WR_POST + ((T_WR > WTR_EXP) ? T_WR : WTR_EXP);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_type = 3'd0;
  logic              burst_done = 1'b0;
  logic              burst_is_wr = 1'b0;
  logic [NBANKS-1:0] bank_open = '0;
  logic              refresh_due = 1'b0;
  logic              wake_req = 1'b0;
  logic [CW-1:0]     cfg_idle_cycles = 8'd200;
  logic [CW-1:0]     cfg_xp_act = 8'd2;
  logic [CW-1:0]     cfg_xp_pre = 8'd1;
  logic              cke;
  logic              cmd_blocked;
  logic              pd_is_active;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cke_pd_sequencer #(
    .NBANKS(NBANKS), .CW(CW), .MAX_OUT(4), .RD_POST(RD_POST), .WR_POST(WR_POST),
    .T_WR(T_WR), .T_WTR_PS(T_WTR_PS), .T_CK_PS(T_CK_PS), .T_MRD(T_MRD),
    .CKE_MIN(CKE_MIN), .MAX_RES(MAX_RES)
  ) i_cke_pd_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .burst_done(burst_done), .burst_is_wr(burst_is_wr), .bank_open(bank_open),
    .refresh_due(refresh_due), .wake_req(wake_req),
    .cfg_idle_cycles(cfg_idle_cycles), .cfg_xp_act(cfg_xp_act),
    .cfg_xp_pre(cfg_xp_pre), .cke(cke), .cmd_blocked(cmd_blocked),
    .pd_is_active(pd_is_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // called at a negedge; returns the number of edges until cke is seen low
  task automatic wait_fall(output int k);
    k = 0;
    while (cke && k < 1000) begin step(); k++; end
  endtask

  task automatic wait_rise(output int k);
    k = 0;
    while (!cke && k < 1000) begin step(); k++; end
  endtask

  task automatic wait_unblock(output int k);
    k = 0;
    while (cmd_blocked && k < 1000) begin step(); k++; end
  endtask

  // called at a negedge in power-down; returns at the first unblocked negedge
  task automatic wake_up();
    int k;
    wake_req = 1'b1;
    step();
    wake_req = 1'b0;
    wait_unblock(k);
  endtask

  task automatic issue(input logic [2:0] code, input int n);
    cfg_idle_cycles = CW'(n);
    cmd_valid = 1'b1;
    cmd_type  = code;
    step();
    cmd_valid = 1'b0;
    cmd_type  = 3'd0;
  endtask

  task automatic burst_case(input logic wr, input int n, input int exp, input string req);
    int k;
    issue(wr ? 3'd2 : 3'd1, n);
    step(); step();
    burst_done  = 1'b1;
    burst_is_wr = wr;
    step();
    burst_done  = 1'b0;
    wait_fall(k);
    chk(req, k, exp);
    wake_up();
  endtask

  initial begin
    int k;
    int j;
    int m;
    int stayed;
    repeat (3) step();
    chk("R1 cke in reset", int'(cke), 1);
    chk("R1 blocked in reset", int'(cmd_blocked), 0);
    rst_n = 1'b1;
    step();
    chk("R1 cke after reset", int'(cke), 1);
    chk("R1 type after reset", int'(pd_is_active), 0);

    // read bursts: busy until done plus postamble
    for (int n = 1; n <= 4; n++) burst_case(1'b0, n, RD_POST + n, "R3 read");
    burst_case(1'b0, 0, RD_POST + 1, "R2 zero threshold");
    // write bursts: postamble plus the larger recovery interval
    for (int n = 1; n <= 4; n++) burst_case(1'b1, n, WR_EXP + n, "R4 write");

    // mode register commands
    for (int n = 1; n <= 3; n++) begin
      issue(3'd3, n);
      wait_fall(k);
      chk("R5 mrs", k, T_MRD + n);
      wake_up();
      issue(3'd4, n);
      wait_fall(k);
      chk("R5 emrs", k, T_MRD + n);
      wake_up();
    end

    // all bank patterns: type, residency, exit delay
    for (int b = 0; b < 16; b++) begin
      cfg_xp_act = CW'((b % 3) + 1);
      cfg_xp_pre = CW'(b % 3);
      bank_open  = NBANKS'(b);
      issue(3'd5, 1);
      wait_fall(k);
      chk("R2 entry after act", k, 1);
      chk("R6 type", int'(pd_is_active), (b != 0) ? 1 : 0);
      chk("R10 blocked low", int'(cmd_blocked), 1);
      bank_open = ~NBANKS'(b);
      if (b % 2 == 0) wake_req = 1'b1; else refresh_due = 1'b1;
      j = 0;
      while (!cke && j < 1000) begin
        step(); j++;
        wake_req = 1'b0;
        if (j == 1) chk("R6 type held", int'(pd_is_active), (b != 0) ? 1 : 0);
      end
      refresh_due = 1'b0;
      chk((b % 2 == 0) ? "R7 wake at min" : "R8 refresh at min", j, CKE_MIN);
      wait_unblock(m);
      chk("R10 exit delay", m, (b != 0) ? (b % 3) + 1 : (b % 3));
    end
    bank_open = '0;

    // maximum residency
    issue(3'd6, 2);
    wait_fall(k);
    chk("R2 entry after pre", k, 2);
    wait_rise(j);
    chk("R9 max residency", j, MAX_RES);
    wait_unblock(m);

    // late refresh forces immediate exit
    issue(3'd7, 1);
    wait_fall(k);
    repeat (7) step();
    refresh_due = 1'b1;
    step();
    chk("R8 late refresh exit", int'(cke), 1);
    refresh_due = 1'b0;
    wait_unblock(m);

    // held wake or refresh prevents entry
    for (int s = 0; s < 2; s++) begin
      if (s == 0) wake_req = 1'b1; else refresh_due = 1'b1;
      issue(3'd5, 1);
      stayed = 1;
      repeat (20) begin step(); if (!cke) stayed = 0; end
      chk("R11 no entry while requested", stayed, 1);
      wake_req = 1'b0;
      refresh_due = 1'b0;
      wait_fall(k);
      chk("R11 entry after release", k, 1);
      wake_up();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule